// File: doc/BRIEF.md
# Multiplexed Input Scanner with Debounce

This block turns one data pin and a five-bit address bus into up to 32 logical inputs. It steps through the addresses of external multiplexer chips and samples the shared data line once for each address. From these samples it keeps two images of the inputs. The raw image holds the latest sample of every input. The filtered image holds the debounced value of every input.

Each input has its own debounce filter. A mask chooses, bit by bit, whether an input uses the short or the long filter threshold. Both thresholds are counted in whole scans. A programmable divisor sets how fast the scan walks through the addresses. An optional global inversion flips every sample before it is stored. Software reaches the block through a small register port with four locations: control, filter select, filtered image and raw image.

Top module: `mux_input_scanner`

## Requirements
- R1: After reset the mux address is 0. The raw image, the filtered image and the filter-select mask are all zero. The writable control fields (invert, divisor, short time, long time) are zero.
- R2: The control word has this layout. Bits 4:0 always read the constant LAST_ADDR, and writes to these bits are ignored. Bit 5 is the invert flag. Bits 15:6 are the 10-bit divisor. Bits 21:16 are the 6-bit short time. Bits 31:22 are the 10-bit long time. The writable fields read back exactly as they were written.
- R3: Register select code 0 is control, 1 is filter select, 2 is the filtered image and 3 is the raw image. Writes to codes 2 and 3 have no effect.
- R4: The mux address steps 0, 1, …, LAST_ADDR and then wraps back to 0. Each address is held for exactly 4*(divisor+1) clock cycles.
- R5: The data line is sampled in the last clock cycle of an address slot. The sample is stored as raw-image bit n, where n is the address.
- R6: When the invert flag is 1, each sample is complemented before it is stored and filtered.
- R7: Let T be the threshold an input uses. The filtered bit takes the new value on the (T+1)-th consecutive sample that differs from it. With T = 0 the filtered bit follows the raw bit directly.
- R8: Any sample that equals the filtered bit clears that input's run count. Differing runs that are broken up and each shorter than T+1 never change the filtered bit.
- R9: Filter-select bit n = 1 gives input n the long time. Bit n = 0 gives it the short time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_addr | output | 5 | Address driven to the external multiplexers |
| mux_data | input | 1 | Shared data line from the multiplexers |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |

## Verification
Random 32-bit input patterns, applied with both thresholds at zero, show that every address lands in its own bit position. Each pattern is also repeated with inversion turned on. A change held for fewer scans than the short threshold, followed by a longer hold, tells the two sides of the threshold apart. A random filter-select mask with unequal short and long times shows that every bit uses its own threshold. Broken-up bursts check that the run count restarts when a matching sample arrives. Timing the address changes at a nonzero divisor checks the slot length and the wrap back to address 0.

// File: rtl/mux_input_scanner.sv
module mux_input_scanner #(
  parameter int LAST_ADDR = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [4:0]  mux_addr,
  input  logic        mux_data,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int NUM_IN = LAST_ADDR + 1;
  localparam int CNT_W  = 10;

  logic              invert;
  logic [9:0]        divisor;
  logic [5:0]        short_t;
  logic [9:0]        long_t;
  logic [NUM_IN-1:0] slow_mask;
  logic [NUM_IN-1:0] raw_img;
  logic [NUM_IN-1:0] filt_img;
  logic [9:0]        pre;
  logic [1:0]        phase;
  logic [CNT_W-1:0]  run_cnt [NUM_IN];

  wire             tick     = (pre >= divisor);
  wire             slot_end = tick && (phase == 2'd3);
  wire             sample   = mux_data ^ invert;
  wire [CNT_W-1:0] thresh   = slow_mask[mux_addr] ? long_t : {4'd0, short_t};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      invert    <= 1'b0;
      divisor   <= '0;
      short_t   <= '0;
      long_t    <= '0;
      slow_mask <= '0;
    end else if (reg_wr) begin
      if (reg_sel == 2'd0) begin
        invert  <= reg_wdata[5];
        divisor <= reg_wdata[15:6];
        short_t <= reg_wdata[21:16];
        long_t  <= reg_wdata[31:22];
      end else if (reg_sel == 2'd1) begin
        slow_mask <= reg_wdata[NUM_IN-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre      <= '0;
      phase    <= '0;
      mux_addr <= '0;
      raw_img  <= '0;
      filt_img <= '0;
      for (int i = 0; i < NUM_IN; i++) run_cnt[i] <= '0;
    end else begin
      pre <= tick ? '0 : pre + 10'd1;
      if (tick) phase <= phase + 2'd1;
      if (slot_end) begin
        raw_img[mux_addr] <= sample;
        if (sample == filt_img[mux_addr]) begin
          run_cnt[mux_addr] <= '0;
        end else if (run_cnt[mux_addr] >= thresh) begin
          filt_img[mux_addr] <= sample;
          run_cnt[mux_addr]  <= '0;
        end else begin
          run_cnt[mux_addr] <= run_cnt[mux_addr] + 1'b1;
        end
        mux_addr <= (mux_addr == 5'(LAST_ADDR)) ? 5'd0 : mux_addr + 5'd1;
      end
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {long_t, short_t, divisor, invert, 5'(LAST_ADDR)};
      2'd1:    reg_rdata = 32'(slow_mask);
      2'd2:    reg_rdata = 32'(filt_img);
      default: reg_rdata = 32'(raw_img);
    endcase
  end
endmodule

// File: rtl/mux_input_scanner_chk.sv
module mux_input_scanner_chk #(
  parameter int LAST_ADDR = 31
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [4:0]           mux_addr,
  input logic [LAST_ADDR:0]   raw_img,
  input logic [LAST_ADDR:0]   filt_img,
  input logic [1:0]           reg_sel,
  input logic [31:0]          reg_rdata
);
  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_addr <= 5'(LAST_ADDR));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_addr != $past(mux_addr)) |->
      ((mux_addr == $past(mux_addr) + 5'd1) ||
       (mux_addr == 5'd0 && $past(mux_addr) == 5'(LAST_ADDR))));

  // R5
  raw_at_slot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_img != $past(raw_img)) |->
      (($countones(raw_img ^ $past(raw_img)) == 1) && (mux_addr != $past(mux_addr))));

  // R7
  filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_img ^ $past(filt_img)) & (filt_img ^ raw_img)) == '0);

  // R2
  ctrl_const_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (reg_rdata[4:0] == 5'(LAST_ADDR)));
endmodule

bind mux_input_scanner mux_input_scanner_chk #(.LAST_ADDR(LAST_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .mux_addr(mux_addr), .raw_img(raw_img),
  .filt_img(filt_img), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
);

// File: tb/mux_input_scanner_tb_top.sv
`timescale 1ns/1ps
module mux_input_scanner_tb_top;
  localparam int LAST  = 31;
  localparam int NIN   = LAST + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mux_addr;
  logic        mux_data;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] ext_in = '0;
  int          checks = 0;
  int          errors = 0;
  int          cur_div = 0;

  always #2.5 clk = ~clk;

  assign mux_data = ext_in[mux_addr];

  mux_input_scanner #(.LAST_ADDR(LAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .mux_addr(mux_addr), .mux_data(mux_data),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] ctrl_word(bit inv, int dv, int sh, int lg);
    return {10'(lg), 6'(sh), 10'(dv), inv, 5'd0};
  endfunction

  function automatic logic [31:0] mix(logic [31:0] old_v, logic [31:0] new_v, logic [31:0] long_m);
    return (new_v & ~long_m) | (old_v & long_m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic set_ctrl(bit inv, int dv, int sh, int lg);
    bus_wr(2'd0, ctrl_word(inv, dv, sh, lg));
    cur_div = dv;
  endtask

  task automatic wait_scans(int n);
    repeat (n * 4 * (cur_div + 1) * NIN) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #5_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd, p_old, p_new, mask;
    int          seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 addr", 32'(mux_addr), 32'd0);
    bus_rd(2'd0, rd); check("R1 ctrl", rd, 32'(LAST));
    bus_rd(2'd1, rd); check("R1 select", rd, 32'd0);
    bus_rd(2'd2, rd); check("R1 filtered", rd, 32'd0);
    bus_rd(2'd3, rd); check("R1 raw", rd, 32'd0);

    // R2 control readback, constant low field
    bus_wr(2'd0, 32'hFFFF_FFE0 | 32'h0000_0011);
    bus_rd(2'd0, rd); check("R2 readback", rd, 32'hFFFF_FFE0 | 32'(LAST));
    set_ctrl(1'b0, 0, 0, 0);
    bus_rd(2'd0, rd); check("R2 zero fields", rd, 32'(LAST));

    // R5 R6 random patterns, thresholds zero, with and without invert
    for (int k = 0; k < 6; k++) begin
      p_new = $urandom();
      @(negedge clk); ext_in = p_new;
      set_ctrl(1'b0, 0, 0, 0);
      wait_scans(2);
      bus_rd(2'd3, rd); check("R5 raw image", rd, p_new);
      bus_rd(2'd2, rd); check("R7 zero threshold follows", rd, p_new);
      set_ctrl(1'b1, 0, 0, 0);
      wait_scans(2);
      bus_rd(2'd3, rd); check("R6 inverted raw", rd, ~p_new);
      bus_rd(2'd2, rd); check("R6 inverted filtered", rd, ~p_new);
    end
    set_ctrl(1'b0, 0, 0, 0);
    wait_scans(2);

    // R3 writes to read-only images ignored
    bus_rd(2'd2, p_old);
    bus_wr(2'd2, ~p_old);
    bus_wr(2'd3, ~p_old);
    bus_rd(2'd2, rd); check("R3 filtered untouched", rd, p_old);
    bus_rd(2'd3, rd); check("R3 raw untouched", rd, p_old);

    // R7 short threshold boundary
    set_ctrl(1'b0, 0, 5, 0);
    p_new = ~p_old;
    @(negedge clk); ext_in = p_new;
    wait_scans(3);
    bus_rd(2'd2, rd); check("R7 held below threshold", rd, p_old);
    bus_rd(2'd3, rd); check("R7 raw tracks", rd, p_new);
    wait_scans(5);
    bus_rd(2'd2, rd); check("R7 changed past threshold", rd, p_new);

    // R8 broken bursts never change the filtered image
    p_old = p_new;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); ext_in = ~p_old;
      wait_scans(3);
      @(negedge clk); ext_in = p_old;
      wait_scans(2);
    end
    bus_rd(2'd2, rd); check("R8 bursts ignored", rd, p_old);
    @(negedge clk); ext_in = ~p_old;
    wait_scans(8);
    bus_rd(2'd2, rd); check("R8 steady change accepted", rd, ~p_old);

    // R9 per-bit long/short selection
    p_old = ~p_old;
    mask = $urandom();
    bus_wr(2'd1, mask);
    bus_rd(2'd1, rd); check("R9 select readback", rd, mask);
    set_ctrl(1'b0, 0, 1, 20);
    p_new = $urandom();
    @(negedge clk); ext_in = p_new;
    wait_scans(4);
    bus_rd(2'd2, rd); check("R9 short bits moved, long held", rd, mix(p_old, p_new, mask));
    wait_scans(25);
    bus_rd(2'd2, rd); check("R9 long bits moved", rd, p_new);
    bus_wr(2'd1, 32'd0);

    // R4 slot length and wrap with divisor 2
    set_ctrl(1'b0, 2, 0, 0);
    begin
      logic [4:0] prev;
      int         run;
      bit         wrapped;
      @(negedge clk); prev = mux_addr;
      while (mux_addr == prev) begin @(negedge clk); end
      prev = mux_addr; run = 0; wrapped = 1'b0;
      for (int t = 0; t < 36; t++) begin
        run = 1;
        @(negedge clk);
        while (mux_addr == prev) begin run++; @(negedge clk); end
        check("R4 slot length", 32'(run), 32'(4 * 3));
        check("R4 address step", 32'(mux_addr), (prev == 5'(LAST)) ? 32'd0 : 32'(prev) + 32'd1);
        if (prev == 5'(LAST)) wrapped = 1'b1;
        prev = mux_addr;
      end
      check("R4 wrap observed", 32'(wrapped), 32'd1);
    end

    finish_run();
  end
endmodule